// File: doc/BRIEF.md
# Prioritized Push Transfer Scheduler for an On-Chip Crossbar

This block decides, every cycle, which transfers may start across an on-chip crossbar that joins a parameterized number of ports. Every port can act as a sender and as a receiver at the same time. A sender raises a request that names a target port, a priority lane (low or high) and a transfer kind. The sender always pushes the data, and the receiver never pulls it. For that reason a transfer starts only when the target reports that it can accept data and is not already taking another transfer.

When a transfer starts, the sender gets a one-cycle grant. The target gets a one-cycle notification that carries the sender's index, the transfer kind and the lane. The crossbar select line of the target then points at the sender for the length of the burst, which is one beat for short kinds and several beats for long kinds. While the burst runs, both ends are marked busy.

The crossbar has a limited number of internal datapaths. No more bursts than that may be in flight at once. High-lane winners claim free datapaths before low-lane winners. Within a lane, each target breaks ties with its own round-robin pointer, which moves past the last sender it served.

Top module: `xbs_sched`

## Requirements
- R1: A grant to a sender is issued only if, at the clock edge before the grant, the sender's request was valid, its target's ready input was 1 and the target was not busy.
- R2: In the cycle a sender's grant is high, the notification of its target is high for that one cycle and carries the sender index, the requested kind and the requested lane.
- R3: Among the requests for one target, a high-lane request (lane bit 1) beats any low-lane request (lane bit 0), whatever the round-robin pointer says.
- R4: The number of busy targets never exceeds NPATHS. When more targets could start than there are free datapaths, high-lane winners are admitted first, then low-lane winners, each group in ascending target index.
- R5: A target carries at most one burst at a time, and a sender holds at most one burst at a time. A request from a busy sender, or to a busy target, waits until the earlier burst is over.
- R6: A kind whose top bit is 0 is short and keeps the target busy for SHORT_BEATS cycles (default 1). A kind whose top bit is 1 is long and keeps the target busy for LONG_BEATS cycles (default 4). The first busy cycle is the grant cycle.
- R7: While a target is busy, its crossbar select equals the index of the sender it serves. While it is idle, the select is 0.
- R8: Within a lane, each target serves the first requesting sender after the one it served last, wrapping around. Before its first grant, the search starts at sender 0.
- R9: A request that is held while its target is not ready draws no grant. The grant comes in the cycle after the ready edge.
- R10: One port can send and receive in the same cycle. Two ports that target each other are both granted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request pending, one bit per sender |
| req_hi | input | NPORTS | Lane of the request: 1 is high, 0 is low |
| req_dest | input | NPORTS*IDW | Target index for each sender |
| req_type | input | NPORTS*2 | Transfer kind for each sender; the top bit selects a long burst |
| dst_ready | input | NPORTS | Target can accept a new transfer |
| grant | output | NPORTS | One-cycle grant pulse per sender |
| src_busy | output | NPORTS | Sender is inside a burst |
| dst_busy | output | NPORTS | Target is inside a burst |
| notify_valid | output | NPORTS | One-cycle notification pulse per target |
| notify_src | output | NPORTS*IDW | Sender index given to each target |
| notify_type | output | NPORTS*2 | Transfer kind given to each target |
| notify_hi | output | NPORTS | Lane given to each target |
| xbar_sel | output | NPORTS*IDW | Crossbar select per target: the sender index while busy |

## Verification
The properties assume that a sender keeps its request valid, with an unchanged target, lane and kind, until its grant appears. They also assume that the sender drops the request, or replaces it, in the grant cycle, and that every target index is below NPORTS. The directed scenarios obey this. Every request is raised on a falling edge and removed on the falling edge where its grant is first seen. Only existing port indices are driven. The arbitration scenarios are run with fewer datapaths than ports, so that the datapath limit is reached on purpose.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int XT_W = 2;

  function automatic logic xt_is_long(input logic [XT_W-1:0] t);
    return t[XT_W-1];
  endfunction

  function automatic int unsigned beats_for(input logic [XT_W-1:0] t,
                                            input int unsigned short_b,
                                            input int unsigned long_b);
    return xt_is_long(t) ? long_b : short_b;
  endfunction
endpackage

// File: rtl/xbs_dest_arb.sv
module xbs_dest_arb #(
  parameter int NPORTS = 8,
  localparam int IDW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic [NPORTS-1:0] cand_hi,
  input  logic [NPORTS-1:0] cand_lo,
  input  logic [IDW-1:0]    last_win,
  output logic              win_valid,
  output logic              win_hi,
  output logic [IDW-1:0]    win_idx
);
  // first set bit after 'last', wrapping around
  function automatic logic [IDW-1:0] rr_first(input logic [NPORTS-1:0] mask,
                                              input logic [IDW-1:0] last);
    logic [IDW-1:0] pick;
    logic got;
    pick = '0;
    got  = 1'b0;
    for (int k = 1; k <= NPORTS; k++) begin
      int idx;
      idx = (int'(last) + k) % NPORTS;
      if (!got && mask[idx]) begin
        pick = IDW'(idx);
        got  = 1'b1;
      end
    end
    return pick;
  endfunction

  logic [NPORTS-1:0] pool;

  always_comb begin
    win_hi    = |cand_hi;
    pool      = win_hi ? cand_hi : cand_lo;
    win_valid = |pool;
    win_idx   = rr_first(pool, last_win);
  end
endmodule

// File: rtl/xbs_path_limit.sv
module xbs_path_limit #(
  parameter int NPORTS = 8,
  parameter int NPATHS = 8
) (
  input  logic [NPORTS-1:0] win_valid,
  input  logic [NPORTS-1:0] win_hi,
  input  logic [NPORTS-1:0] busy,
  output logic [NPORTS-1:0] admit
);
  int unsigned busy_n;
  int unsigned free_n;
  int unsigned used_n;

  always_comb begin
    busy_n = $countones(busy);
    free_n = (busy_n >= NPATHS) ? 0 : (NPATHS - busy_n);
    used_n = 0;
    admit  = '0;
    for (int d = 0; d < NPORTS; d++) begin
      if (win_valid[d] && win_hi[d] && used_n < free_n) begin
        admit[d] = 1'b1;
        used_n   = used_n + 1;
      end
    end
    for (int d = 0; d < NPORTS; d++) begin
      if (win_valid[d] && !win_hi[d] && used_n < free_n) begin
        admit[d] = 1'b1;
        used_n   = used_n + 1;
      end
    end
  end
endmodule

// File: rtl/xbs_sched.sv
module xbs_sched import xbs_pkg::*; #(
  parameter int NPORTS      = 8,
  parameter int NPATHS      = 8,
  parameter int SHORT_BEATS = 1,
  parameter int LONG_BEATS  = 4,
  localparam int IDW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int MAXB = (LONG_BEATS > SHORT_BEATS) ? LONG_BEATS : SHORT_BEATS,
  localparam int CW = $clog2(MAXB + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS-1:0]      req_valid,
  input  logic [NPORTS-1:0]      req_hi,
  input  logic [NPORTS*IDW-1:0]  req_dest,
  input  logic [NPORTS*XT_W-1:0] req_type,
  input  logic [NPORTS-1:0]      dst_ready,
  output logic [NPORTS-1:0]      grant,
  output logic [NPORTS-1:0]      src_busy,
  output logic [NPORTS-1:0]      dst_busy,
  output logic [NPORTS-1:0]      notify_valid,
  output logic [NPORTS*IDW-1:0]  notify_src,
  output logic [NPORTS*XT_W-1:0] notify_type,
  output logic [NPORTS-1:0]      notify_hi,
  output logic [NPORTS*IDW-1:0]  xbar_sel
);
  logic [CW-1:0]     beat_cnt [NPORTS];
  logic [IDW-1:0]    owner    [NPORTS];
  logic [IDW-1:0]    rr_last  [NPORTS];
  logic [NPORTS-1:0] cand_hi  [NPORTS];
  logic [NPORTS-1:0] cand_lo  [NPORTS];
  logic [IDW-1:0]    win_idx  [NPORTS];
  logic [XT_W-1:0]   win_type [NPORTS];
  logic [NPORTS-1:0] win_valid, win_hi;
  logic [NPORTS-1:0] evt_start;   // per target: a burst starts at this edge
  logic [NPORTS-1:0] grant_nx;

  // busy state of both ends
  always_comb begin
    src_busy = '0;
    for (int d = 0; d < NPORTS; d++) begin
      dst_busy[d] = (beat_cnt[d] != '0);
      xbar_sel[d*IDW +: IDW] = dst_busy[d] ? owner[d] : '0;
      for (int s = 0; s < NPORTS; s++)
        if (dst_busy[d] && owner[d] == IDW'(s)) src_busy[s] = 1'b1;
    end
  end

  // eligible requests, sorted per target and lane
  always_comb begin
    for (int d = 0; d < NPORTS; d++) begin
      for (int s = 0; s < NPORTS; s++) begin
        logic ok;
        ok = req_valid[s] && !src_busy[s] && dst_ready[d] && !dst_busy[d]
             && (req_dest[s*IDW +: IDW] == IDW'(d));
        cand_hi[d][s] = ok && req_hi[s];
        cand_lo[d][s] = ok && !req_hi[s];
      end
    end
  end

  for (genvar d = 0; d < NPORTS; d++) begin : g_arb
    xbs_dest_arb #(.NPORTS(NPORTS)) u_arb (
      .cand_hi  (cand_hi[d]),
      .cand_lo  (cand_lo[d]),
      .last_win (rr_last[d]),
      .win_valid(win_valid[d]),
      .win_hi   (win_hi[d]),
      .win_idx  (win_idx[d])
    );
    assign win_type[d] = req_type[win_idx[d]*XT_W +: XT_W];
  end

  xbs_path_limit #(.NPORTS(NPORTS), .NPATHS(NPATHS)) u_lim (
    .win_valid(win_valid),
    .win_hi   (win_hi),
    .busy     (dst_busy),
    .admit    (evt_start)
  );

  always_comb begin
    grant_nx = '0;
    for (int d = 0; d < NPORTS; d++)
      if (evt_start[d]) grant_nx[win_idx[d]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant        <= '0;
      notify_valid <= '0;
      notify_src   <= '0;
      notify_type  <= '0;
      notify_hi    <= '0;
      for (int d = 0; d < NPORTS; d++) begin
        beat_cnt[d] <= '0;
        owner[d]    <= '0;
        rr_last[d]  <= IDW'(NPORTS - 1);
      end
    end else begin
      grant <= grant_nx;
      for (int d = 0; d < NPORTS; d++) begin
        notify_valid[d] <= evt_start[d];
        if (evt_start[d]) begin
          beat_cnt[d] <= CW'(beats_for(win_type[d], SHORT_BEATS, LONG_BEATS));
          owner[d]    <= win_idx[d];
          rr_last[d]  <= win_idx[d];
          notify_src[d*IDW +: IDW]    <= win_idx[d];
          notify_type[d*XT_W +: XT_W] <= win_type[d];
          notify_hi[d]                <= win_hi[d];
        end else if (beat_cnt[d] != '0) begin
          beat_cnt[d] <= beat_cnt[d] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbs_sched_chk.sv
module xbs_sched_chk import xbs_pkg::*; #(
  parameter int NPORTS      = 8,
  parameter int NPATHS      = 8,
  parameter int SHORT_BEATS = 1,
  parameter int LONG_BEATS  = 4,
  localparam int IDW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORTS-1:0]      req_valid,
  input logic [NPORTS*IDW-1:0]  req_dest,
  input logic [NPORTS*XT_W-1:0] req_type,
  input logic [NPORTS-1:0]      dst_ready,
  input logic [NPORTS-1:0]      grant,
  input logic [NPORTS-1:0]      src_busy,
  input logic [NPORTS-1:0]      dst_busy,
  input logic [NPORTS-1:0]      notify_valid,
  input logic [NPORTS*IDW-1:0]  notify_src,
  input logic [NPORTS*XT_W-1:0] notify_type
);
  assert_path_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dst_busy) <= NPATHS);

  for (genvar s = 0; s < NPORTS; s++) begin : g_src
    assert_grant_needs_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grant[s] |-> $past(req_valid[s]));
    assert_one_burst_per_sender_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant[s] |-> !$past(src_busy[s]));
  end

  for (genvar d = 0; d < NPORTS; d++) begin : g_dst
    logic [7:0] run_len, want_len;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_len  <= '0;
        want_len <= '0;
      end else if (notify_valid[d]) begin
        run_len  <= 8'd1;
        want_len <= 8'(beats_for(notify_type[d*XT_W +: XT_W], SHORT_BEATS, LONG_BEATS));
      end else if (dst_busy[d]) begin
        run_len <= run_len + 8'd1;
      end
    end

    assert_target_was_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid[d] |-> ($past(dst_ready[d]) && !$past(dst_busy[d])));
    assert_burst_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dst_busy[d]) |-> (run_len == want_len));

    for (genvar s = 0; s < NPORTS; s++) begin : g_pair
      assert_notify_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (notify_valid[d] && notify_src[d*IDW +: IDW] == IDW'(s)) |->
          (grant[s] && $past(req_dest[s*IDW +: IDW]) == IDW'(d)
           && notify_type[d*XT_W +: XT_W] == $past(req_type[s*XT_W +: XT_W])));
    end
  end
endmodule

bind xbs_sched xbs_sched_chk #(
  .NPORTS(NPORTS), .NPATHS(NPATHS), .SHORT_BEATS(SHORT_BEATS), .LONG_BEATS(LONG_BEATS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
  .req_type(req_type), .dst_ready(dst_ready), .grant(grant), .src_busy(src_busy),
  .dst_busy(dst_busy), .notify_valid(notify_valid), .notify_src(notify_src),
  .notify_type(notify_type)
);

// File: tb/sim_xbs_sched.sv
module sim_xbs_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int NDP = 2;
  localparam int IW  = 2;
  localparam int TW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0, req_hi = '0, dst_ready = '1;
  logic [NP*IW-1:0] req_dest = '0;
  logic [NP*TW-1:0] req_type = '0;
  logic [NP-1:0]    grant, src_busy, dst_busy, notify_valid, notify_hi;
  logic [NP*IW-1:0] notify_src, xbar_sel;
  logic [NP*TW-1:0] notify_type;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbs_sched #(.NPORTS(NP), .NPATHS(NDP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hi(req_hi),
    .req_dest(req_dest), .req_type(req_type), .dst_ready(dst_ready),
    .grant(grant), .src_busy(src_busy), .dst_busy(dst_busy),
    .notify_valid(notify_valid), .notify_src(notify_src), .notify_type(notify_type),
    .notify_hi(notify_hi), .xbar_sel(xbar_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input int s, input int d, input bit hi, input int t);
    req_valid[s] = 1'b1;
    req_hi[s] = hi;
    req_dest[s*IW +: IW] = IW'(d);
    req_type[s*TW +: TW] = TW'(t);
  endtask

  task automatic drop(input int s);
    req_valid[s] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset grant", 32'(grant), 0);
    chk("R5 reset busy", 32'({src_busy, dst_busy}), 0);
    chk("R2 reset notify", 32'(notify_valid), 0);
  endtask

  task automatic t_short();
    put(2, 1, 0, 1);
    tick();
    chk("R2 grant", 32'(grant), 32'b0100);
    chk("R2 notify", 32'(notify_valid), 32'b0010);
    chk("R2 notify src", 32'(notify_src[1*IW +: IW]), 2);
    chk("R2 notify kind", 32'(notify_type[1*TW +: TW]), 1);
    chk("R2 notify lane", 32'(notify_hi[1]), 0);
    chk("R7 select", 32'(xbar_sel[1*IW +: IW]), 2);
    chk("R5 dst busy", 32'(dst_busy), 32'b0010);
    chk("R5 src busy", 32'(src_busy), 32'b0100);
    drop(2);
    tick();
    chk("R6 short over", 32'(dst_busy), 0);
    chk("R7 idle select", 32'(xbar_sel), 0);
  endtask

  task automatic t_not_ready();
    dst_ready[3] = 1'b0;
    put(1, 3, 0, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 held no grant", 32'(grant), 0);
    end
    dst_ready[3] = 1'b1;
    tick();
    chk("R1 grant after ready", 32'(grant), 32'b0010);
    drop(1);
    tick();
  endtask

  task automatic t_long();
    put(0, 2, 0, 2);
    tick();
    chk("R6 long grant", 32'(grant), 32'b0001);
    chk("R6 long busy first", 32'(dst_busy), 32'b0100);
    drop(0);
    put(3, 2, 1, 0);
    for (int k = 2; k <= 5; k++) begin
      tick();
      chk("R6 long busy", 32'(dst_busy[2]), (k <= 4) ? 1 : 0);
      chk("R5 target held", 32'(grant[3]), 0);
    end
    tick();
    chk("R5 grant after burst", 32'(grant), 32'b1000);
    drop(3);
    tick();
  endtask

  task automatic t_lanes_rr();
    put(1, 0, 0, 0);
    put(2, 0, 1, 0);
    put(3, 0, 0, 0);
    tick();
    chk("R3 high lane wins", 32'(grant), 32'b0100);
    chk("R3 notify lane", 32'(notify_hi[0]), 1);
    drop(2);
    tick();
    chk("R5 target busy", 32'(grant), 0);
    tick();
    chk("R8 rr after 2", 32'(grant), 32'b1000);
    drop(3);
    tick();
    chk("R5 target busy 2", 32'(grant), 0);
    tick();
    chk("R8 rr wraps to 1", 32'(grant), 32'b0010);
    drop(1);
    tick();
  endtask

  task automatic t_paths();
    put(0, 1, 0, 2);
    put(1, 2, 0, 2);
    put(2, 3, 0, 2);
    tick();
    chk("R4 two admitted", 32'(grant), 32'b0011);
    chk("R4 busy", 32'(dst_busy), 32'b0110);
    drop(0);
    drop(1);
    for (int k = 2; k <= 5; k++) begin
      tick();
      chk("R4 third waits", 32'(grant[2]), 0);
    end
    tick();
    chk("R4 third admitted", 32'(grant), 32'b0100);
    drop(2);
    repeat (6) tick();
    put(0, 1, 0, 0);
    put(1, 2, 0, 0);
    put(2, 3, 1, 0);
    tick();
    chk("R4 high lane first", 32'(grant), 32'b0101);
    drop(0);
    drop(2);
    tick();
    chk("R4 low waits", 32'(grant), 0);
    tick();
    chk("R4 low admitted", 32'(grant), 32'b0010);
    drop(1);
    tick();
  endtask

  task automatic t_cross();
    put(0, 1, 0, 0);
    put(1, 0, 0, 0);
    tick();
    chk("R10 both granted", 32'(grant), 32'b0011);
    chk("R10 src busy", 32'(src_busy), 32'b0011);
    chk("R10 dst busy", 32'(dst_busy), 32'b0011);
    chk("R7 select 0", 32'(xbar_sel[0 +: IW]), 1);
    chk("R7 select 1", 32'(xbar_sel[IW +: IW]), 0);
    drop(0);
    drop(1);
    tick();
  endtask

  task automatic t_sender_once();
    put(0, 1, 0, 2);
    tick();
    chk("R5 first grant", 32'(grant), 32'b0001);
    put(0, 2, 0, 0);
    for (int k = 2; k <= 5; k++) begin
      tick();
      chk("R5 sender busy", 32'(grant), 0);
    end
    tick();
    chk("R5 sender next grant", 32'(grant), 32'b0001);
    chk("R2 next notify", 32'(notify_valid), 32'b0100);
    drop(0);
    tick();
  endtask

  initial begin
    repeat (2) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_short();
    t_not_ready();
    t_long();
    t_lanes_rr();
    t_paths();
    t_cross();
    t_sender_once();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule